// File: doc/BRIEF.md
# Configuration Bitstream Header Parser

This block inspects a programmable-logic configuration file as it streams past, one byte per accepted handshake, before the file is handed to the device loader. It walks the human-readable header fields by their length bytes and reads the manufacturing year out of the date field. It then hunts for the sync marker and decodes the 24-bit payload bit count packed in the bytes after it. Finally it checks that the declared payload fits inside the file length supplied at start.

A parse begins with a start pulse that samples the file length and clears every result. Bytes are taken while `in_ready_o` is high. When the parse ends, `done_o` pulses for one cycle, and `ok_o` or a two-bit error code remains on the outputs until the next start. The string contents are never stored. Only the length bytes steer the field walk, and only date characters are interpreted.

Top module: `cfg_hdr_parser`

## Requirements
- R1: The byte index is counted from 0, starting with the first byte taken after start. The index of the first byte equal to 0xFF is reported on `mark_off_o`, which stays 0 if no marker is seen.
- R2: If `file_len_i` bytes have been taken without a 0xFF byte, or `file_len_i` is 0, the parse ends with error code 1 (no marker).
- R3: The byte after the marker must carry 0x2 in bits 7:4. Any other value ends the parse on that byte with error code 2 (bad tag), and `bit_cnt_o` stays 0.
- R4: The bit count is built as follows. Tag byte bits 3:0 go to bits 23:20. The next byte goes to bits 19:12, the byte after it to bits 11:4, and bits 7:4 of the fourth byte to bits 3:0. The count is shown on `bit_cnt_o` once the fourth byte is taken, whatever the final status.
- R5: After the fourth count byte, the parse ends with error code 3 (too short) if the marker index plus floor(count/8) exceeds the file length; equality passes with `ok_o`. If the file ends before all four count bytes arrive, the code is also 3.
- R6: Byte 15 holds the name length; 0 means 12. After the name, two more bytes follow, then the type length byte; 0 means 10. After the type, two more bytes follow, then the date length byte; 0 means 11. The date field holds that many bytes and ends early at a 0x00 byte.
- R7: Within the date, digit runs are read as decimal numbers. The first run to end at 2000 or above fixes `year_o`. Otherwise `year_o` holds the current run, and a non-digit after a run below 2000 resets it to 0. Only date bytes taken before the parse ends count.
- R8: `feat_o` is high exactly when `year_o` is 2001 or more and `feat_block_i` is low.
- R9: `done_o` is a single-cycle pulse, one cycle after the terminating byte or after the last byte when the file runs out. With it, either `ok_o` is high and the code is 0, or `ok_o` is low and the code is non-zero. Both hold until the next start.
- R10: A start while idle clears every result output and samples `file_len_i`. A start while a parse is running is ignored.
- R11: `in_ready_o` is high exactly while a parse is running and fewer than `file_len_i` bytes have been taken. Bytes offered past the file length are never taken.
- R12: After reset, `in_ready_o`, `done_o`, `ok_o`, `err_o` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a parse (taken only when idle) |
| file_len_i | input | LEN_W | Total file length in bytes, sampled at start |
| feat_block_i | input | 1 | Suppresses the feature flag |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Parser can take a byte |
| done_o | output | 1 | One-cycle end-of-parse pulse |
| ok_o | output | 1 | Header accepted |
| err_o | output | 2 | 0 none, 1 no marker, 2 bad tag, 3 too short |
| mark_off_o | output | LEN_W | Index of the sync marker |
| bit_cnt_o | output | 24 | Decoded payload bit count |
| year_o | output | YEAR_W | Year read from the date field |
| feat_o | output | 1 | Feature flag derived from the year |

## Verification
The bench uses the default widths: a 32-bit byte counter and a 16-bit year. Files of a few dozen bytes are enough to place the marker, the length-check boundary in both directions, a truncated count and a zero-length file. With a 16-bit year, every date used stays clear of accumulator wrap. A start is also pulsed in the middle of a running parse, and valid is gapped in one case, so that the cycle-exact model catches any slip in the ready and done timing.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NO_MARK = 2'd1,
        ERR_BAD_TAG = 2'd2,
        ERR_SHORT   = 2'd3
    } cfgp_err_e;

    // Header field walk: which length-delimited region the next byte is in
    typedef enum logic [2:0] {
        W_END  = 3'd0,
        W_LEAD = 3'd1,
        W_NAME = 3'd2,
        W_TYPE = 3'd3,
        W_DATE = 3'd4
    } walk_e;

    // Sync marker hunt and count assembly
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HUNT = 2'd1,
        S_CNT  = 2'd2
    } sync_e;

    localparam int CNT_W = 24;

endpackage

// File: rtl/cfgp_field_walk.sv
module cfgp_field_walk
    import cfgp_pkg::*;
#(
    parameter int YEAR_W      = 16,
    parameter int NAME_LEN_AT = 15,
    parameter int DEF_NAME    = 12,
    parameter int DEF_TYPE    = 10,
    parameter int DEF_DATE    = 11,
    parameter int YEAR_FLOOR  = 2000,
    parameter int FEAT_YEAR   = 2001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [7:0]        byte_i,
    input  logic              feat_block_i,
    output logic [YEAR_W-1:0] year_o,
    output logic              feat_o
);

    localparam int REM_W = 9;

    typedef struct packed {
        walk_e             phase;
        logic [REM_W-1:0]  rem;
        logic [YEAR_W-1:0] year;
        logic              locked;
        logic              feat;
    } walk_t;

    walk_t walk_d, walk_q;

    function automatic logic [REM_W-1:0] len_or(input logic [7:0] b, input int dflt);
        return (b == 8'd0) ? REM_W'(dflt) : {1'b0, b};
    endfunction

    logic is_digit;
    assign is_digit = (byte_i >= 8'h30) && (byte_i <= 8'h39);

    always_comb begin
        walk_d = walk_q;
        if (clr_i) begin
            walk_d        = '0;
            walk_d.phase  = W_LEAD;
            walk_d.rem    = REM_W'(NAME_LEN_AT);
        end else if (take_i) begin
            unique case (walk_q.phase)
                W_LEAD: begin
                    if (walk_q.rem == '0) begin
                        walk_d.phase = W_NAME;
                        walk_d.rem   = len_or(byte_i, DEF_NAME) + REM_W'(2);
                    end else begin
                        walk_d.rem = walk_q.rem - 1'b1;
                    end
                end
                W_NAME: begin
                    if (walk_q.rem == '0) begin
                        walk_d.phase = W_TYPE;
                        walk_d.rem   = len_or(byte_i, DEF_TYPE) + REM_W'(2);
                    end else begin
                        walk_d.rem = walk_q.rem - 1'b1;
                    end
                end
                W_TYPE: begin
                    if (walk_q.rem == '0) begin
                        walk_d.phase = W_DATE;
                        walk_d.rem   = len_or(byte_i, DEF_DATE);
                    end else begin
                        walk_d.rem = walk_q.rem - 1'b1;
                    end
                end
                W_DATE: begin
                    if ((walk_q.rem == '0) || (byte_i == 8'd0)) begin
                        walk_d.phase = W_END;
                    end else begin
                        walk_d.rem = walk_q.rem - 1'b1;
                        if (!walk_q.locked) begin
                            if (is_digit) begin
                                walk_d.year = YEAR_W'(walk_q.year * 10) + YEAR_W'(byte_i - 8'h30);
                            end else if (walk_q.year >= YEAR_W'(YEAR_FLOOR)) begin
                                walk_d.locked = 1'b1;
                            end else begin
                                walk_d.year = '0;
                            end
                        end
                    end
                end
                default: ;
            endcase
            walk_d.feat = (walk_d.year >= YEAR_W'(FEAT_YEAR)) && !feat_block_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign year_o = walk_q.year;
    assign feat_o = walk_q.feat;

endmodule

// File: rtl/cfgp_sync_decode.sv
module cfgp_sync_decode
    import cfgp_pkg::*;
#(
    parameter int         LEN_W = 32,
    parameter logic [7:0] MARK  = 8'hFF,
    parameter logic [3:0] TAG   = 4'h2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             take_i,
    input  logic [7:0]       byte_i,
    input  logic [LEN_W-1:0] idx_i,
    output logic             found_o,
    output logic [LEN_W-1:0] off_o,
    output logic             bad_tag_o,
    output logic             last_o,
    output logic [CNT_W-1:0] cnt_full_o
);

    typedef struct packed {
        sync_e            phase;
        logic [1:0]       k;
        logic             found;
        logic [LEN_W-1:0] off;
        logic [CNT_W-1:0] cnt;
    } sync_t;

    sync_t sync_d, sync_q;

    logic in_cnt;
    assign in_cnt     = take_i && (sync_q.phase == S_CNT);
    assign bad_tag_o  = in_cnt && (sync_q.k == 2'd0) && (byte_i[7:4] != TAG);
    assign last_o     = in_cnt && (sync_q.k == 2'd3);
    assign cnt_full_o = {sync_q.cnt[CNT_W-1:4], byte_i[7:4]};

    always_comb begin
        sync_d = sync_q;
        if (clr_i) begin
            sync_d       = '0;
            sync_d.phase = S_HUNT;
        end else if (take_i) begin
            unique case (sync_q.phase)
                S_HUNT: begin
                    if (byte_i == MARK) begin
                        sync_d.phase = S_CNT;
                        sync_d.found = 1'b1;
                        sync_d.off   = idx_i;
                        sync_d.k     = 2'd0;
                    end
                end
                S_CNT: begin
                    sync_d.k = sync_q.k + 1'b1;
                    unique case (sync_q.k)
                        2'd0: begin
                            if (bad_tag_o) sync_d.phase = S_IDLE;
                            else           sync_d.cnt[23:20] = byte_i[3:0];
                        end
                        2'd1: sync_d.cnt[19:12] = byte_i;
                        2'd2: sync_d.cnt[11:4]  = byte_i;
                        default: begin
                            sync_d.cnt[3:0] = byte_i[7:4];
                            sync_d.phase    = S_IDLE;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign found_o = sync_q.found;
    assign off_o   = sync_q.off;

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
    import cfgp_pkg::*;
#(
    parameter int LEN_W  = 32,
    parameter int YEAR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  file_len_i,
    input  logic              feat_block_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    output logic              in_ready_o,
    output logic              done_o,
    output logic              ok_o,
    output logic [1:0]        err_o,
    output logic [LEN_W-1:0]  mark_off_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              feat_o
);

    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic             done;
        logic             ok;
        cfgp_err_e        err;
        logic [CNT_W-1:0] bits;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             room, take, clr, busy_w;
    logic             found, bad_tag, last;
    logic [LEN_W-1:0] off;
    logic [CNT_W-1:0] cnt_full;
    logic [LEN_W:0]   need;

    assign busy_w = ctl_q.busy;
    assign room   = ctl_q.cnt != ctl_q.len;
    assign take   = in_valid_i && ctl_q.busy && room;
    assign clr    = start_i && !ctl_q.busy;
    assign need   = {1'b0, off} + (LEN_W+1)'(cnt_full >> 3);

    cfgp_sync_decode #(.LEN_W(LEN_W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .take_i     (take),
        .byte_i     (in_data_i),
        .idx_i      (ctl_q.cnt),
        .found_o    (found),
        .off_o      (off),
        .bad_tag_o  (bad_tag),
        .last_o     (last),
        .cnt_full_o (cnt_full)
    );

    cfgp_field_walk #(.YEAR_W(YEAR_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr),
        .take_i       (take),
        .byte_i       (in_data_i),
        .feat_block_i (feat_block_i),
        .year_o       (year_o),
        .feat_o       (feat_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (clr) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = '0;
            ctl_d.len  = file_len_i;
            ctl_d.ok   = 1'b0;
            ctl_d.err  = ERR_NONE;
            ctl_d.bits = '0;
        end else if (ctl_q.busy) begin
            if (!room) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.err  = found ? ERR_SHORT : ERR_NO_MARK;
            end else if (take) begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (bad_tag) begin
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.err  = ERR_BAD_TAG;
                end else if (last) begin
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.bits = cnt_full;
                    if (need > {1'b0, ctl_q.len}) ctl_d.err = ERR_SHORT;
                    else                          ctl_d.ok  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign in_ready_o = ctl_q.busy && room;
    assign done_o     = ctl_q.done;
    assign ok_o       = ctl_q.ok;
    assign err_o      = ctl_q.err;
    assign mark_off_o = off;
    assign bit_cnt_o  = ctl_q.bits;

endmodule

// File: rtl/cfgp_checks.sv
module cfgp_checks #(
    parameter int LEN_W     = 32,
    parameter int YEAR_W    = 16,
    parameter int FEAT_YEAR = 2001
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy,
    input logic              in_ready_o,
    input logic              done_o,
    input logic              ok_o,
    input logic [1:0]        err_o,
    input logic [LEN_W-1:0]  mark_off_o,
    input logic [23:0]       bit_cnt_o,
    input logic [YEAR_W-1:0] year_o,
    input logic              feat_o
);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ok_o ^ (err_o != 2'd0)));

    assert_start_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (!ok_o && err_o == 2'd0 && bit_cnt_o == '0
                                && mark_off_o == '0 && year_o == '0 && !feat_o));

    assert_ready_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> busy);

    assert_done_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy && $past(busy)));

    assert_feat_year_R8: assert property (@(posedge clk) disable iff (!rst_n)
        feat_o |-> (year_o >= YEAR_W'(FEAT_YEAR)));

endmodule

bind cfg_hdr_parser cfgp_checks #(.LEN_W(LEN_W), .YEAR_W(YEAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy       (busy_w),
    .in_ready_o (in_ready_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .err_o      (err_o),
    .mark_off_o (mark_off_o),
    .bit_cnt_o  (bit_cnt_o),
    .year_o     (year_o),
    .feat_o     (feat_o)
);

// File: tb/cfg_hdr_parser_bench.sv
module cfg_hdr_parser_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] file_len_i = '0;
    logic        feat_block_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic        in_ready_o, done_o, ok_o, feat_o;
    logic [1:0]  err_o;
    logic [31:0] mark_off_o;
    logic [23:0] bit_cnt_o;
    logic [15:0] year_o;

    always #2 clk = ~clk;

    cfg_hdr_parser u_cfg_hdr_parser (.*);

    int tests = 0, fails = 0, cyc = 0;
    logic [7:0] fq[$];
    int mk;
    int e_term, e_err, e_off, e_year;
    logic e_ok, e_feat;
    logic [23:0] e_bits;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog: run did not end, got %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // name/type/date length codes, date text, filler count, tag nibble, count, payload size
    task automatic build(input int flc, input int tlc, input int dlc, input string ds,
                         input int fill, input logic [3:0] tag, input logic [23:0] c,
                         input int pay);
        int fl = (flc == 0) ? 12 : flc;
        int tl = (tlc == 0) ? 10 : tlc;
        int dl = (dlc == 0) ? 11 : dlc;
        fq.delete();
        for (int i = 0; i < 15; i++) fq.push_back(8'h11);
        fq.push_back(8'(flc));
        for (int i = 0; i < fl + 2; i++) fq.push_back(8'h6E);
        fq.push_back(8'(tlc));
        for (int i = 0; i < tl + 2; i++) fq.push_back(8'h74);
        fq.push_back(8'(dlc));
        for (int i = 0; i < dl; i++) fq.push_back(i < ds.len() ? 8'(ds.getc(i)) : 8'h00);
        for (int i = 0; i < fill; i++) fq.push_back(8'h7A);
        mk = fq.size();
        fq.push_back(8'hFF);
        fq.push_back({tag, c[23:20]});
        fq.push_back(c[19:12]);
        fq.push_back(c[11:4]);
        fq.push_back({c[3:0], 4'h5});
        for (int i = 0; i < pay; i++) fq.push_back(8'(i));
    endtask

    function automatic logic dig(input logic [7:0] b);
        return b >= 8'h30 && b <= 8'h39;
    endfunction

    // Behavioural reference for one file of length len
    task automatic ref_parse(input int len, input logic dis);
        int i = 0, last, fl, tp, tl, dp, dl, k, n, yr;
        logic [7:0] ch[$];
        e_term = -1; e_err = 0; e_ok = 0; e_off = 0; e_bits = '0;
        while (i < len && fq[i] != 8'hFF) i++;
        if (i >= len) begin
            e_err = 1; last = len - 1;
        end else begin
            e_off = i;
            if (i + 1 >= len) begin
                e_err = 3; last = len - 1;
            end else if (fq[i+1][7:4] != 4'h2) begin
                e_err = 2; e_term = i + 1; last = i + 1;
            end else if (i + 4 >= len) begin
                e_err = 3; last = len - 1;
            end else begin
                e_bits = {fq[i+1][3:0], fq[i+2], fq[i+3], fq[i+4][7:4]};
                e_term = i + 4; last = i + 4;
                if (i + int'(e_bits / 8) > len) e_err = 3; else e_ok = 1;
            end
        end
        yr = 0;
        if (last >= 15) begin
            fl = (fq[15] == 0) ? 12 : fq[15];
            tp = 16 + fl + 2;
            if (tp <= last) begin
                tl = (fq[tp] == 0) ? 10 : fq[tp];
                dp = tp + 1 + tl + 2;
                if (dp <= last) begin
                    dl = (fq[dp] == 0) ? 11 : fq[dp];
                    for (int j = 0; j < dl; j++) begin
                        if (dp + 1 + j > last || fq[dp+1+j] == 8'h00) break;
                        ch.push_back(fq[dp+1+j]);
                    end
                end
            end
        end
        n = ch.size(); k = 0;
        do begin
            while (k < n && !dig(ch[k])) k++;
            yr = 0;
            while (k < n && dig(ch[k])) begin yr = yr * 10 + (ch[k] - 8'h30); k++; end
        end while (yr < 2000 && k < n);
        e_year = yr;
        e_feat = (yr >= 2001) && !dis;
    endtask

    task automatic run(input string name, input int len, input logic dis,
                       input logic gap, input logic midstart);
        int mi = 0;
        logic mbusy = 1'b1, mdone = 1'b0, nd, v;
        ref_parse(len, dis);
        @(negedge clk);
        start_i = 1'b1; file_len_i = 32'(len); feat_block_i = dis;
        @(negedge clk);
        start_i = 1'b0;
        chk({name, " R10 ok cleared"}, ok_o, 0);
        chk({name, " R10 err cleared"}, err_o, 0);
        chk({name, " R10 bits cleared"}, bit_cnt_o, 0);
        for (int c = 0; c < 3000; c++) begin
            start_i = (midstart && c == 3);
            v = gap ? (c % 3 != 1) : 1'b1;
            in_valid_i = v;
            in_data_i  = (mi < fq.size()) ? fq[mi] : 8'hFF;
            chk({name, " R11 ready"}, in_ready_o, mbusy && mi != len);
            chk({name, " R9 done timing"}, done_o, mdone);
            if (mdone) break;
            nd = 1'b0;
            if (mbusy) begin
                if (mi == len) begin
                    mbusy = 1'b0; nd = 1'b1;
                end else if (v) begin
                    mi++;
                    if (mi - 1 == e_term) begin mbusy = 1'b0; nd = 1'b1; end
                end
            end
            mdone = nd;
            @(negedge clk);
        end
        in_valid_i = 1'b0; start_i = 1'b0;
        chk({name, " R9 ok"}, ok_o, e_ok);
        chk({name, " R2 R3 R5 err code"}, err_o, e_err);
        chk({name, " R1 marker offset"}, mark_off_o, e_off);
        chk({name, " R4 bit count"}, bit_cnt_o, e_bits);
        chk({name, " R6 R7 year"}, year_o, e_year);
        chk({name, " R8 feature"}, feat_o, e_feat);
        @(negedge clk);
        chk({name, " R9 done one cycle"}, done_o, 0);
        chk({name, " R9 status held"}, err_o, e_err);
        chk({name, " R11 idle ready"}, in_ready_o, 0);
    endtask

    initial begin
        #1;
        chk("R12 reset ready", in_ready_o, 0);
        chk("R12 reset done", done_o, 0);
        chk("R12 reset ok", ok_o, 0);
        chk("R12 reset err", err_o, 0);
        chk("R12 reset year", year_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        build(5, 4, 11, "Mar 14 2001", 3, 4'h2, 24'h000100, 40);
        run("R8 year 2001 flag set", fq.size(), 1'b0, 1'b0, 1'b0);
        run("R8 flag blocked gapped", fq.size(), 1'b1, 1'b1, 1'b0);
        run("R10 restart ignored", fq.size(), 1'b0, 1'b0, 1'b1);
        run("R2 no marker before end", mk, 1'b0, 1'b0, 1'b0);
        run("R5 truncated count", mk + 3, 1'b0, 1'b0, 1'b0);

        build(0, 0, 0, "Jun 9 2000a", 2, 4'h2, 24'h000100, 40);
        run("R6 default lengths year 2000", fq.size(), 1'b0, 1'b0, 1'b0);

        build(3, 3, 6, "1999 x", 1, 4'h2, 24'h000100, 40);
        run("R7 run below floor reset", fq.size(), 1'b0, 1'b0, 1'b0);

        build(2, 2, 6, "19", 0, 4'h2, 24'h000100, 40);
        run("R6 date NUL end", fq.size(), 1'b0, 1'b1, 1'b0);

        build(4, 4, 9, "2007-2010", 2, 4'h3, 24'h000100, 40);
        run("R3 bad tag", fq.size(), 1'b0, 1'b0, 1'b0);

        build(4, 4, 4, "2002", 2, 4'h2, 24'h000028, 0);
        run("R5 exact fit passes", mk + 5, 1'b0, 1'b0, 1'b0);

        build(4, 4, 4, "2002", 2, 4'h2, 24'h000030, 0);
        run("R5 one byte over fails", mk + 5, 1'b0, 1'b0, 1'b0);

        build(1, 1, 4, "2030", 5, 4'h2, 24'hA5C3E7, 8);
        run("R4 wide count short file", fq.size(), 1'b0, 1'b1, 1'b0);

        run("R2 zero length", 0, 1'b0, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule